// File: doc/BRIEF.md
# Comparator Output Flag Controller

This block is the digital back-end of an analog comparator. It takes the comparator's raw output, which is assumed to already be in the bus clock domain, and produces a filtered output. The filter takes a new sample on a sample tick. The tick comes from one of two sources: an internal down-counter whose period is set in bus clocks, or an external sample strobe. A period of zero turns the filter off, and the output then tracks the raw input.

From the filtered output the block sets a rising flag and a falling flag. Software clears these by writing one to them. The flags drive an interrupt request and a DMA request. In low-power stop mode the flags can be level-sensitive or edge-sensitive, as software selects. Software sees two byte-wide registers: a status/control register and a filter-period register. The reset input is asynchronous, active low, and already released in step with the clock.

Top module: `cmp_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, and `irq` and `dma_req` are low. Bit 7 of the status/control register (address 0) always reads 0. Its other bits are: 6 DMA enable, 5 stop edge select, 4 rising interrupt enable, 3 falling interrupt enable, 2 rising flag, 1 falling flag, 0 filtered output (read-only).
- R2: When the period register (address 1) is 0 and `samp_ext_en` is low, `cmp_out` takes the value of `cmp_raw` from the previous clock.
- R3: When the period register holds P (nonzero) and `samp_ext_en` is low, `cmp_out` samples `cmp_raw` on the P-th clock edge after the period write, and on every P-th edge after that. Between those edges it holds. The period register reads back the written value.
- R4: When `samp_ext_en` is high, the period register has no effect. `cmp_out` samples `cmp_raw` on the second clock edge after the edge that first sees `samp_strobe` high. A strobe that stays high causes no further samples.
- R5: Outside stop mode, a rising flag is set one clock after `cmp_out` goes from 0 to 1, and a falling flag is set one clock after it goes from 1 to 0. A flag stays set until it is cleared.
- R6: Writing 1 to bit 2 or bit 1 at address 0 clears the rising flag or the falling flag. Writing 0 to a flag bit leaves that flag unchanged.
- R7: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: `irq` is high when the rising flag and bit 4 are both set, or when the falling flag and bit 3 are both set.
- R9: `dma_req` is high when bit 6 is set and either flag is set. Otherwise it is low.
- R10: In stop mode with bit 5 at 0, the rising flag is set in every cycle after one in which `cmp_out` is 1, and the falling flag in every cycle after one in which `cmp_out` is 0.
- R11: In stop mode with bit 5 at 1, the flags are set only by transitions of `cmp_out`, as in R5. A steady level sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator output |
| stop_mode | input | 1 | Low-power stop mode indication |
| samp_ext_en | input | 1 | Selects the external sample strobe instead of the period counter |
| samp_strobe | input | 1 | External sample strobe; its rising edge is synchronised |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: status/control, 1: filter period |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| cmp_out | output | 1 | Filtered comparator output |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench targets the cases where a hardware set and a write-one clear land on the same flag in the same cycle. A design that lets the clear win there would silently lose a comparator event. It checks the difference between level and edge behaviour in stop mode. A mix-up there would leave a flag stuck low while the output is steady, or would refire a flag right after software clears it. It counts the exact edge on which a programmed period or an external strobe lets a new sample through. A counter that is off by one, or a strobe that is not edge-detected, shows up as an early, late or repeated update. It also confirms that the period value has no effect in strobe mode.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

  localparam int REG_W = 8;

  typedef enum logic {
    ADDR_CTL = 1'b0,
    ADDR_PER = 1'b1
  } cmp_addr_e;

  typedef struct packed {
    logic dma_en;
    logic edge_sel;
    logic ie_rise;
    logic ie_fall;
  } cmp_ctl_t;

  localparam int BIT_DMA  = 6;
  localparam int BIT_EDGE = 5;
  localparam int BIT_IER  = 4;
  localparam int BIT_IEF  = 3;
  localparam int BIT_FR   = 2;
  localparam int BIT_FF   = 1;

endpackage

// File: rtl/cmp_samp_tick.sv
module cmp_samp_tick #(
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_sel,
  input  logic          strobe,
  input  logic [PW-1:0] period,
  input  logic          period_wr,
  input  logic [PW-1:0] period_wdata,
  output logic          tick
);

  logic [SYNC_STAGES:0] sync_q;
  logic [PW-1:0]        cnt_q, cnt_d;
  logic                 ext_tick, int_tick, bypass;

  // Synchroniser chain plus one extra stage for edge detection
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= strobe;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ext_tick = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign bypass   = !ext_sel && (period == '0);
  assign int_tick = (cnt_q == '0);

  always_comb begin
    if (period_wr)
      cnt_d = (period_wdata == '0) ? '0 : period_wdata - 1'b1;
    else if (ext_sel || period == '0)
      cnt_d = '0;
    else if (cnt_q == '0)
      cnt_d = period - 1'b1;
    else
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    if (ext_sel)     tick = ext_tick;
    else if (bypass) tick = 1'b1;
    else             tick = int_tick;
  end

endmodule

// File: rtl/cmp_filt_edge.sv
module cmp_filt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt,
  output logic rise_evt,
  output logic fall_evt
);

  logic filt_q, filt_d, prev_q;

  always_comb filt_d = tick ? raw : filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      filt_q <= filt_d;
      prev_q <= filt_q;
    end
  end

  assign filt     = filt_q;
  assign rise_evt = filt_q & ~prev_q;
  assign fall_evt = ~filt_q & prev_q;

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic filt,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic stop_mode,
  input  logic edge_sel,
  input  logic clr_rise,
  input  logic clr_fall,
  output logic set_rise,
  output logic set_fall,
  output logic flag_rise,
  output logic flag_fall
);

  logic fr_q, ff_q, fr_d, ff_d, level_mode;

  assign level_mode = stop_mode && !edge_sel;

  always_comb begin
    set_rise = level_mode ? filt  : rise_evt;
    set_fall = level_mode ? ~filt : fall_evt;
    fr_d = set_rise | (fr_q & ~clr_rise);
    ff_d = set_fall | (ff_q & ~clr_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      ff_q <= 1'b0;
    end else begin
      fr_q <= fr_d;
      ff_q <= ff_d;
    end
  end

  assign flag_rise = fr_q;
  assign flag_fall = ff_q;

endmodule

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
  import cmp_flag_pkg::*;
#(
  parameter int PW          = REG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             stop_mode,
  input  logic             samp_ext_en,
  input  logic             samp_strobe,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             cmp_out,
  output logic             irq,
  output logic             dma_req
);

  cmp_ctl_t      ctl_q, ctl_d;
  logic [PW-1:0] period_q, period_d;
  logic          ctl_en, per_en;
  logic          samp_tick, rise_evt, fall_evt;
  logic          set_rise, set_fall, flag_rise, flag_fall;
  logic          clr_rise, clr_fall;
  logic          edge_sel, dma_en;

  assign ctl_en   = reg_wr && (cmp_addr_e'(reg_addr) == ADDR_CTL);
  assign per_en   = reg_wr && (cmp_addr_e'(reg_addr) == ADDR_PER);
  assign clr_rise = ctl_en && reg_wdata[BIT_FR];
  assign clr_fall = ctl_en && reg_wdata[BIT_FF];
  assign edge_sel = ctl_q.edge_sel;
  assign dma_en   = ctl_q.dma_en;

  always_comb begin
    ctl_d    = ctl_q;
    period_d = period_q;
    if (ctl_en) begin
      ctl_d.dma_en   = reg_wdata[BIT_DMA];
      ctl_d.edge_sel = reg_wdata[BIT_EDGE];
      ctl_d.ie_rise  = reg_wdata[BIT_IER];
      ctl_d.ie_fall  = reg_wdata[BIT_IEF];
    end
    if (per_en) period_d = reg_wdata[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      period_q <= '0;
    end else begin
      ctl_q    <= ctl_d;
      period_q <= period_d;
    end
  end

  cmp_samp_tick #(.PW(PW), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_sel      (samp_ext_en),
    .strobe       (samp_strobe),
    .period       (period_q),
    .period_wr    (per_en),
    .period_wdata (reg_wdata[PW-1:0]),
    .tick         (samp_tick)
  );

  cmp_filt_edge u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (samp_tick),
    .raw      (cmp_raw),
    .filt     (cmp_out),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  cmp_flag_unit u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt      (cmp_out),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .stop_mode (stop_mode),
    .edge_sel  (ctl_q.edge_sel),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .set_rise  (set_rise),
    .set_fall  (set_fall),
    .flag_rise (flag_rise),
    .flag_fall (flag_fall)
  );

  assign irq     = (ctl_q.ie_rise & flag_rise) | (ctl_q.ie_fall & flag_fall);
  assign dma_req = ctl_q.dma_en & (flag_rise | flag_fall);

  always_comb begin
    reg_rdata = '0;
    if (cmp_addr_e'(reg_addr) == ADDR_PER)
      reg_rdata[PW-1:0] = period_q;
    else
      reg_rdata = {1'b0, ctl_q.dma_en, ctl_q.edge_sel, ctl_q.ie_rise,
                   ctl_q.ie_fall, flag_rise, flag_fall, cmp_out};
  end

endmodule

// File: rtl/cmp_flag_chk.sv
module cmp_flag_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_raw,
  input logic          stop_mode,
  input logic          samp_ext_en,
  input logic          reg_wr,
  input logic          reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          cmp_out,
  input logic          dma_req,
  input logic          samp_tick,
  input logic          set_rise,
  input logic          flag_rise,
  input logic          edge_sel,
  input logic          dma_en,
  input logic [PW-1:0] period_q
);

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !samp_ext_en && period_q == '0) |-> cmp_out == $past(cmp_raw)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(samp_tick)) |-> $stable(cmp_out)); // R3

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past($rose(cmp_out))) |-> flag_rise); // R5

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && reg_wr && !reg_addr && reg_wdata[2] && !set_rise) |-> !flag_rise); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && set_rise) |-> flag_rise); // R7

  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req); // R9

  AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && stop_mode && !edge_sel && cmp_out) |-> flag_rise); // R10

endmodule

bind cmp_flag_ctrl cmp_flag_chk #(.PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_raw     (cmp_raw),
  .stop_mode   (stop_mode),
  .samp_ext_en (samp_ext_en),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .cmp_out     (cmp_out),
  .dma_req     (dma_req),
  .samp_tick   (samp_tick),
  .set_rise    (set_rise),
  .flag_rise   (flag_rise),
  .edge_sel    (edge_sel),
  .dma_en      (dma_en),
  .period_q    (period_q)
);

// File: tb/sim_cmp_flag_ctrl.sv
`timescale 1ns/1ps
module sim_cmp_flag_ctrl;

  logic       clk = 1'b0;
  logic       rst_n, cmp_raw, stop_mode, samp_ext_en, samp_strobe;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cmp_out, irq, dma_req;
  int         checks = 0;
  int         errors = 0;

  always #4 clk = ~clk;

  cmp_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .stop_mode(stop_mode),
    .samp_ext_en(samp_ext_en), .samp_strobe(samp_strobe), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_out(cmp_out), .irq(irq), .dma_req(dma_req)
  );

  // Bits: [7] stop, [6] raw, [5:4] clear mask (rise, fall), [3] cout, [2] rise flag, [1] fall flag
  localparam logic [7:0] VEC [13] = '{
    8'h48, 8'h4C, 8'h20, 8'h02, 8'h10, 8'h48, 8'h24,
    8'h22, 8'h92, 8'hCA, 8'hDC, 8'hEC, 8'h68
  };
  localparam logic [7:0] CTL_ALL = 8'h58;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; cmp_raw = 1'b0; stop_mode = 1'b0; samp_ext_en = 1'b0;
    samp_strobe = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 ctl", reg_rdata, 8'h00);
    chk("R1 irq/dma", {6'd0, irq, dma_req}, 8'h00);
    reg_addr = 1'b1; #1;
    chk("R1 period", reg_rdata, 8'h00);
    reg_addr = 1'b0;
    wr(1'b0, 8'hF8);
    chk("R1 bit7 zero", reg_rdata, 8'h78);
    wr(1'b0, CTL_ALL);

    // Table: bypass filter, R2 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 13; i++) begin
      stop_mode = VEC[i][7];
      cmp_raw   = VEC[i][6];
      if (VEC[i][5:4] != 2'b00) begin
        reg_wr = 1'b1; reg_addr = 1'b0;
        reg_wdata = CTL_ALL | {5'd0, VEC[i][5:4], 1'b0};
      end
      step();
      reg_wr = 1'b0; reg_wdata = '0;
      chk("R2 cout", {7'd0, cmp_out}, {7'd0, VEC[i][3]});
      chk("R5/R7/R10 flags", {6'd0, reg_rdata[2:1]}, {6'd0, VEC[i][2:1]});
      chk("R8 irq", {7'd0, irq}, {7'd0, VEC[i][2] | VEC[i][1]});
      chk("R9 dma", {7'd0, dma_req}, {7'd0, VEC[i][2] | VEC[i][1]});
    end

    // R11 stop edge mode: steady high sets nothing, fall sets falling flag
    wr(1'b0, 8'h78);
    stop_mode = 1'b1;
    step();
    chk("R11 no level set", {6'd0, reg_rdata[2:1]}, 8'h00);
    cmp_raw = 1'b0;
    step(); step();
    chk("R11 edge set", {6'd0, reg_rdata[2:1]}, 8'h01);

    // R6 writing zero to flags
    wr(1'b0, 8'h78);
    chk("R6 zero write no effect", {6'd0, reg_rdata[2:1]}, 8'h01);

    // R8 R9 enables
    wr(1'b0, 8'h10);
    chk("R8 rise enable only", {6'd0, irq, dma_req}, 8'h00);
    wr(1'b0, 8'h08);
    chk("R8 fall enable", {6'd0, irq, dma_req}, 8'h02);
    wr(1'b0, 8'h40);
    chk("R9 dma enable", {6'd0, irq, dma_req}, 8'h01);
    stop_mode = 1'b0;
    wr(1'b0, 8'h46);
    chk("R9 dma no flags", {7'd0, dma_req}, 8'h00);

    // R3 period 4
    wr(1'b1, 8'h04);
    reg_addr = 1'b1; #1;
    chk("R3 period readback", reg_rdata, 8'h04);
    reg_addr = 1'b0;
    cmp_raw = 1'b1;
    step(); step(); step();
    chk("R3 held", {7'd0, cmp_out}, 8'h00);
    step();
    chk("R3 sampled", {7'd0, cmp_out}, 8'h01);
    cmp_raw = 1'b0;
    step(); step(); step();
    chk("R3 held again", {7'd0, cmp_out}, 8'h01);
    step();
    chk("R3 sampled again", {7'd0, cmp_out}, 8'h00);

    // R4 external strobe, period ignored
    wr(1'b1, 8'h00);
    samp_ext_en = 1'b1;
    cmp_raw = 1'b1;
    step(); step(); step();
    chk("R4 period ignored", {7'd0, cmp_out}, 8'h00);
    samp_strobe = 1'b1;
    step(); step();
    chk("R4 before tick", {7'd0, cmp_out}, 8'h00);
    step();
    chk("R4 tick", {7'd0, cmp_out}, 8'h01);
    cmp_raw = 1'b0;
    step(); step(); step(); step();
    chk("R4 held strobe", {7'd0, cmp_out}, 8'h01);

    summary();
  end

endmodule